// File: doc/BRIEF.md
# Four-Lane Float Greater-or-Equal Compare Unit

This block compares two 128-bit vectors, each taken as four single-precision IEEE-754 words. For each lane it returns a 32-bit mask: all ones when the A word is greater than or equal to the B word, and all zeros otherwise. The compare is quiet and ordered. A NaN on either side makes the lane false, and nothing is signalled.

A mode register can turn on denormal flushing. When flushing is on, a denormal operand is treated as a zero of its own sign before the compare. The block also forms a 4-bit condition summary that reports whether every lane passed or no lane passed. That summary carries a write-enable, which is raised only when the instruction word presented with the operands has its record flag set. A small front end finds that flag in either of two instruction encodings.

Operands are accepted on a valid strobe. The mask, the summary and the write-enable appear on the next clock edge together with an output valid.

Top module: `vfge_unit`

## Requirements
- R1: Lane k occupies bits 32k+31..32k of each vector, for k = 0 to 3. When in_valid is high, that lane of out_mask becomes 32'hFFFFFFFF if A >= B as floats, and 32'h00000000 otherwise.
- R2: If either word of a lane is a NaN (exponent field all ones and a nonzero fraction), that lane's mask is zero. This holds even when both words are the same NaN.
- R3: Zeros of either sign are equal, so +0 >= -0 and -0 >= +0 are both true.
- R4: Non-NaN values are ordered by sign and magnitude. Any negative value is below any positive value, a larger magnitude is more negative, and infinities order as ordinary values: +Inf >= +Inf is true and -Inf >= +Inf is false.
- R5: With flushing on, a denormal (exponent zero, fraction nonzero) compares as a zero of its sign. With flushing off, it compares by its true value, so 32'h00000000 >= 32'h00000001 is false.
- R6: The flush mode bit is 1 after reset. It loads cfg_flush on any clock where cfg_we is high, and the new value applies to operands accepted on later clocks.
- R7: out_cr is {all lanes true, 0, no lane true, 0} with bit 3 as the MSB. For example, all true gives 4'b1000, none true gives 4'b0010, and mixed lanes give 4'b0000.
- R8: out_cr_we is the record flag of the accepted instruction word, and it is low whenever no operands were accepted on the previous clock. With in_ext_enc = 0 the flag is in_instr[10] (bit 21 counting the MSB as bit 0). With in_ext_enc = 1 it is in_instr[4] (bit 27 in that numbering).
- R9: out_valid is high exactly on the cycle after a clock where in_valid was high. Reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the flush mode bit |
| cfg_flush | input | 1 | New flush mode value |
| in_valid | input | 1 | Operand strobe |
| in_a | input | 128 | Source vector A |
| in_b | input | 128 | Source vector B |
| in_instr | input | 32 | Instruction word carrying the record flag |
| in_ext_enc | input | 1 | 1 selects the extended-encoding flag position |
| out_valid | output | 1 | Result valid |
| out_mask | output | 128 | Per-lane compare mask |
| out_cr | output | 4 | Condition summary |
| out_cr_we | output | 1 | Condition summary write-enable |

## Verification
The bench targets the cases that a magnitude-only or integer compare gets wrong:
- Negative pairs: a design that forgets to reverse the magnitude order for two negatives reports -2 >= -1.
- Signed zeros: a design that skips the both-zero escape reports -0 < +0.
- NaNs: a design that ignores them treats identical NaN words as equal.
- Denormals: these are tested with flushing on and off, both before and after a reset, so a lost flush or a wrong reset default changes the lane result.
- Record flag: it is placed at both encodings' positions while the other encoding is selected, which exposes a front end that reads the wrong bit.
- Condition summary: the all-true, none-true and mixed patterns are each checked, which exposes swapped or mis-placed summary bits.

// File: rtl/vfge_pkg.sv
package vfge_pkg;
  parameter int LANE_W  = 32;
  parameter int LANES   = 4;
  parameter int EXP_W   = 8;
  parameter int FRAC_W  = 23;
  parameter int INSTR_W = 32;
  // Record flag positions, numbered with bit 0 as the MSB of the word
  parameter int REC_POS_STD = 21;
  parameter int REC_POS_EXT = 27;
  localparam int VEC_W = LANE_W * LANES;
  localparam int CR_W  = 4;
endpackage

// File: rtl/vfge_lane.sv
module vfge_lane
  import vfge_pkg::*;
(
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic              flush_i,
  output logic              ge_o
);
  localparam int MAG_W = LANE_W - 1;

  logic             a_sign, b_sign;
  logic [EXP_W-1:0] a_exp, b_exp;
  logic [FRAC_W-1:0] a_frac, b_frac;
  logic             a_nan, b_nan, a_den, b_den;
  logic [MAG_W-1:0] a_mag, b_mag;
  logic             both_zero;

  always_comb begin
    a_sign = a_i[LANE_W-1];
    b_sign = b_i[LANE_W-1];
    a_exp  = a_i[LANE_W-2 -: EXP_W];
    b_exp  = b_i[LANE_W-2 -: EXP_W];
    a_frac = a_i[FRAC_W-1:0];
    b_frac = b_i[FRAC_W-1:0];
    a_nan  = (&a_exp) && (|a_frac);
    b_nan  = (&b_exp) && (|b_frac);
    a_den  = (a_exp == '0) && (|a_frac);
    b_den  = (b_exp == '0) && (|b_frac);
    a_mag  = (flush_i && a_den) ? '0 : a_i[MAG_W-1:0];
    b_mag  = (flush_i && b_den) ? '0 : b_i[MAG_W-1:0];
    both_zero = (a_mag == '0) && (b_mag == '0);

    if (a_nan || b_nan)        ge_o = 1'b0;
    else if (both_zero)        ge_o = 1'b1;
    else if (a_sign != b_sign) ge_o = ~a_sign;
    else if (!a_sign)          ge_o = (a_mag >= b_mag);
    else                       ge_o = (a_mag <= b_mag);
  end
endmodule

// File: rtl/vfge_recsel.sv
module vfge_recsel
  import vfge_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               ext_i,
  output logic               rec_o
);
  localparam int STD_IDX = INSTR_W - 1 - REC_POS_STD;
  localparam int EXT_IDX = INSTR_W - 1 - REC_POS_EXT;

  always_comb begin
    rec_o = ext_i ? instr_i[EXT_IDX] : instr_i[STD_IDX];
  end
endmodule

// File: rtl/vfge_unit.sv
module vfge_unit
  import vfge_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_flush,
  input  logic               in_valid,
  input  logic [VEC_W-1:0]   in_a,
  input  logic [VEC_W-1:0]   in_b,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic               in_ext_enc,
  output logic               out_valid,
  output logic [VEC_W-1:0]   out_mask,
  output logic [CR_W-1:0]    out_cr,
  output logic               out_cr_we
);
  // Reset synchronizer: asserts at once, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [LANES-1:0] lane_ge;
  logic             flush_q, flush_d;
  logic             rec_flag;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    vfge_lane u_lane (
      .a_i    (in_a[k*LANE_W +: LANE_W]),
      .b_i    (in_b[k*LANE_W +: LANE_W]),
      .flush_i(flush_q),
      .ge_o   (lane_ge[k])
    );
  end

  vfge_recsel u_recsel (
    .instr_i(in_instr),
    .ext_i  (in_ext_enc),
    .rec_o  (rec_flag)
  );

  logic               valid_d, cr_we_d;
  logic [VEC_W-1:0]   mask_d;
  logic [CR_W-1:0]    cr_d;

  always_comb begin
    flush_d = cfg_we ? cfg_flush : flush_q;
    valid_d = in_valid;
    cr_we_d = in_valid & rec_flag;
    mask_d  = out_mask;
    cr_d    = out_cr;
    if (in_valid) begin
      for (int k = 0; k < LANES; k++)
        mask_d[k*LANE_W +: LANE_W] = {LANE_W{lane_ge[k]}};
      cr_d = {&lane_ge, 1'b0, ~|lane_ge, 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      flush_q   <= 1'b1;
      out_valid <= 1'b0;
      out_cr_we <= 1'b0;
      out_mask  <= '0;
      out_cr    <= '0;
    end else begin
      flush_q   <= flush_d;
      out_valid <= valid_d;
      out_cr_we <= cr_we_d;
      out_mask  <= mask_d;
      out_cr    <= cr_d;
    end
  end
endmodule

// File: rtl/vfge_unit_chk.sv
module vfge_unit_chk
  import vfge_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [INSTR_W-1:0] in_instr,
  input logic               in_ext_enc,
  input logic               out_valid,
  input logic [VEC_W-1:0]   out_mask,
  input logic [CR_W-1:0]    out_cr,
  input logic               out_cr_we
);
  localparam int STD_IDX = INSTR_W - 1 - REC_POS_STD;
  localparam int EXT_IDX = INSTR_W - 1 - REC_POS_EXT;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
  AST_REC_STD_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ext_enc) |=> (out_cr_we == $past(in_instr[STD_IDX]))); // R8
  AST_REC_EXT_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ext_enc) |=> (out_cr_we == $past(in_instr[EXT_IDX]))); // R8
  AST_CR_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_cr_we |-> out_valid); // R8
  AST_CR_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    out_cr_we |-> (out_cr[2] == 1'b0 && out_cr[0] == 1'b0)); // R7
  AST_CR_ALL_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    out_cr_we |-> (out_cr[3] == (&out_mask))); // R7
  AST_CR_NONE_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    out_cr_we |-> (out_cr[1] == ~(|out_mask))); // R7

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    AST_LANE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((&out_mask[k*LANE_W +: LANE_W]) || (out_mask[k*LANE_W +: LANE_W] == '0))); // R1
  end
endmodule

bind vfge_unit vfge_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_instr  (in_instr),
  .in_ext_enc(in_ext_enc),
  .out_valid (out_valid),
  .out_mask  (out_mask),
  .out_cr    (out_cr),
  .out_cr_we (out_cr_we)
);

// File: tb/vfge_unit_test.sv
module vfge_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_we, cfg_flush, in_valid, in_ext_enc;
  logic [127:0] in_a, in_b;
  logic [31:0]  in_instr;
  logic         out_valid, out_cr_we;
  logic [127:0] out_mask;
  logic [3:0]   out_cr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk; // 250 MHz

  vfge_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_flush(cfg_flush),
    .in_valid(in_valid), .in_a(in_a), .in_b(in_b), .in_instr(in_instr),
    .in_ext_enc(in_ext_enc), .out_valid(out_valid), .out_mask(out_mask),
    .out_cr(out_cr), .out_cr_we(out_cr_we)
  );

  localparam logic [31:0] REC_STD = 32'h0000_0400; // in_instr[10]
  localparam logic [31:0] REC_EXT = 32'h0000_0010; // in_instr[4]
  localparam logic [31:0] ONE  = 32'h3F80_0000;
  localparam logic [31:0] TWO  = 32'h4000_0000;

  // {a, b, expected ge, requirement number}; flushing on
  localparam int NV = 16;
  localparam logic [71:0] VEC [NV] = '{
    {32'h3F80_0000, 32'h3F80_0000, 1'b1, 7'd1},  // R1 equal
    {32'h4000_0000, 32'h3F80_0000, 1'b1, 7'd1},  // R1 greater
    {32'h3F80_0000, 32'h4000_0000, 1'b0, 7'd1},  // R1 less
    {32'h7FC0_0000, 32'h3F80_0000, 1'b0, 7'd2},  // R2 NaN in A
    {32'h3F80_0000, 32'h7F80_0001, 1'b0, 7'd2},  // R2 NaN in B
    {32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 7'd2},  // R2 same NaN
    {32'h0000_0000, 32'h8000_0000, 1'b1, 7'd3},  // R3 +0 >= -0
    {32'h8000_0000, 32'h0000_0000, 1'b1, 7'd3},  // R3 -0 >= +0
    {32'hBF80_0000, 32'hC000_0000, 1'b1, 7'd4},  // R4 -1 >= -2
    {32'hC000_0000, 32'hBF80_0000, 1'b0, 7'd4},  // R4 -2 >= -1
    {32'hBF80_0000, 32'h3F80_0000, 1'b0, 7'd4},  // R4 -1 >= 1
    {32'h7F80_0000, 32'h7F80_0000, 1'b1, 7'd4},  // R4 +Inf
    {32'hFF80_0000, 32'h7F80_0000, 1'b0, 7'd4},  // R4 -Inf vs +Inf
    {32'h0000_0001, 32'h0000_0000, 1'b1, 7'd5},  // R5 denorm vs 0
    {32'h0000_0000, 32'h0000_0001, 1'b1, 7'd5},  // R5 0 vs denorm
    {32'h8000_0001, 32'h0000_0000, 1'b1, 7'd5}   // R5 neg denorm
  };

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply one operand set; outputs are sampled on the following falling edge
  task automatic apply(input logic [127:0] a, input logic [127:0] b,
                       input logic [31:0] instr, input logic ext);
    @(negedge clk);
    in_a = a; in_b = b; in_instr = instr; in_ext_enc = ext; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic lane_check(input logic [31:0] a, input logic [31:0] b,
                            input bit exp, input string req);
    apply({3{ONE}} & 128'h0 | {96'h0, a}, {96'h0, b}, 32'h0, 1'b0);
    check(out_valid == 1'b1, "R9", {127'h0, out_valid}, 128'h1);
    check(out_mask[31:0] == {32{exp}}, req, {96'h0, out_mask[31:0]},
          {96'h0, {32{exp}}});
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_flush = 1'b0; in_valid = 1'b0;
    in_a = '0; in_b = '0; in_instr = '0; in_ext_enc = 1'b0;
    #1;
    // R9 reset state
    check(out_valid == 1'b0, "R9", {127'h0, out_valid}, 128'h0);
    check(out_cr_we == 1'b0, "R8", {127'h0, out_cr_we}, 128'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: pair placed in lane i%4, other lanes hold 0 vs 0 (true)
    for (int i = 0; i < NV; i++) begin
      logic [31:0] va, vb;
      logic        ge;
      int          ln, rq;
      logic [127:0] a, b;
      va = VEC[i][71:40]; vb = VEC[i][39:8]; ge = VEC[i][7]; rq = int'(VEC[i][6:0]);
      ln = i % 4;
      a = '0; b = '0;
      a[ln*32 +: 32] = va; b[ln*32 +: 32] = vb;
      apply(a, b, 32'h0, 1'b0);
      check(out_mask[ln*32 +: 32] == {32{ge}}, $sformatf("R%0d vec %0d", rq, i),
            {96'h0, out_mask[ln*32 +: 32]}, {96'h0, {32{ge}}});
      check(out_mask == ~({96'h0, {32{~ge}}} << (ln*32)), "R1 other lanes",
            out_mask, ~({96'h0, {32{~ge}}} << (ln*32)));
    end

    // R9: no new strobe, valid drops
    @(negedge clk);
    check(out_valid == 1'b0, "R9", {127'h0, out_valid}, 128'h0);
    check(out_cr_we == 1'b0, "R8", {127'h0, out_cr_we}, 128'h0);

    // R7 / R8 summary patterns
    apply({4{TWO}}, {4{ONE}}, REC_STD, 1'b0);
    check(out_cr_we == 1'b1, "R8 std flag", {127'h0, out_cr_we}, 128'h1);
    check(out_cr == 4'b1000, "R7 all true", {124'h0, out_cr}, {124'h0, 4'b1000});
    apply({4{ONE}}, {4{TWO}}, REC_EXT, 1'b1);
    check(out_cr_we == 1'b1, "R8 ext flag", {127'h0, out_cr_we}, 128'h1);
    check(out_cr == 4'b0010, "R7 none true", {124'h0, out_cr}, {124'h0, 4'b0010});
    apply({ONE, TWO, ONE, TWO}, {4{ONE}} ^ {96'h0, 32'h0} | {TWO, 96'h0} , REC_STD, 1'b0);
    check(out_cr == 4'b0000, "R7 mixed", {124'h0, out_cr}, 128'h0);
    apply({4{TWO}}, {4{ONE}}, REC_EXT, 1'b0);
    check(out_cr_we == 1'b0, "R8 ext bit with std enc", {127'h0, out_cr_we}, 128'h0);
    apply({4{TWO}}, {4{ONE}}, REC_STD, 1'b1);
    check(out_cr_we == 1'b0, "R8 std bit with ext enc", {127'h0, out_cr_we}, 128'h0);

    // R5 / R6: flushing off
    @(negedge clk); cfg_we = 1'b1; cfg_flush = 1'b0;
    @(negedge clk); cfg_we = 1'b0;
    lane_check(32'h0000_0001, 32'h0000_0000, 1'b1, "R5 no flush denorm>0");
    lane_check(32'h0000_0000, 32'h0000_0001, 1'b0, "R6 flush off 0<denorm");
    lane_check(32'h8000_0001, 32'h0000_0000, 1'b0, "R5 no flush neg denorm");

    // R6: reset restores flushing
    do_reset();
    check(out_valid == 1'b0, "R9 after reset", {127'h0, out_valid}, 128'h0);
    lane_check(32'h0000_0000, 32'h0000_0001, 1'b1, "R6 flush default");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule